// File: doc/BRIEF.md
# PCI Type-0 Configuration Header

This block holds the 64-byte configuration header of one PCI device function. A simple register port reaches it. Each access carries a byte offset, a size in bytes, a read or write strobe and, for writes, 32 bits of data. Most header fields are constants that load from parameters at reset. A small set of fields accepts writes, and whether a write lands depends on both the access size and the offset.

Six base address registers support the usual size-probing handshake. Software writes all ones and reads back a mask that reveals the window size, with the space-type bits left intact. Software then writes a base address, which places a decode window. The block compares a presented bus address against every placed window and raises one hit line per BAR. The expansion ROM register has its own probe rule. Illegal sizes and writes to read-only fields raise a one-cycle error pulse.

Top module: `pci_cfg_header`

## Requirements
- R1: Out of reset the header reads back the parameter values in standard type-0 layout, little-endian. A read of 1, 2 or 4 bytes returns the bytes from the offset upward in `cfg_rdata` one cycle after `cfg_rd`. Unused upper bytes are zero, and bytes past offset 0x3F read as zero. After reset `cfg_rdata`, `cfg_err` and `bar_hit` are all zero.
- R2: A read or write whose size is not 1, 2 or 4 (for example 3 or 5) raises `cfg_err` for exactly one cycle after the strobe and changes no state. Such a read returns zero.
- R3: A 1-byte write changes state only at 0x0C (cache line size), 0x0D (latency timer) or 0x3C (interrupt line). At any other offset it raises `cfg_err` and is dropped.
- R4: A 2-byte write changes state only at 0x04 (command), 0x06 (status) or 0x0C (cache line size in the low byte, latency timer in the high byte). At any other offset it raises `cfg_err` and is dropped.
- R5: A 4-byte write at 0x04 updates only the 16-bit command field and leaves status alone. A 4-byte write at any offset other than 0x04, a BAR or the ROM register is ignored with no error.
- R6: A 4-byte write of 0xFFFFFFFF to an implemented BAR (offset 0x10 + 4·n, n = 0..5) stores ~(size − 1), ORed with the low type bits. The type bits are the low 2 bits when bit 0 is 1 (I/O) and the low 4 bits otherwise (memory).
- R7: Any other 4-byte BAR write stores the written value with the low 2 bits (I/O) or low 4 bits (memory) kept at their old contents. The type bits never change after reset.
- R8: A 4-byte write of 0xFFFFFFFE to the ROM register at 0x30 makes it read 0xFFFFFFFF. Any other 4-byte value is stored as written.
- R9: A non-probe BAR write whose value, with bit 0 (I/O) or bits 1:0 (memory) cleared, is non-zero places that value plus `IO_WIN_OFS` or `MEM_WIN_OFS` as the window base. `bar_hit[n]` is then high, combinationally, for every `bus_addr` from base to base + size − 1.
- R10: A BAR gives no hit until a base has been placed. A write whose masked value is zero and an all-ones probe both leave an existing window where it is. Reset removes every window.
- R11: A BAR whose size parameter is 0 reads as zero, ignores all writes and never hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_rd | input | 1 | Read strobe, one cycle per access |
| cfg_wr | input | 1 | Write strobe, one cycle per access |
| cfg_off | input | 6 | Byte offset into the header |
| cfg_size | input | 3 | Access size in bytes |
| cfg_wdata | input | 32 | Write data, right-aligned |
| cfg_rdata | output | 32 | Read data, valid the cycle after `cfg_rd` |
| cfg_err | output | 1 | One-cycle pulse for a bad size or a rejected write |
| bus_addr | input | 32 | Address to match against the BAR windows |
| bar_hit | output | 6 | Per-BAR window hit |

## Verification
On every cycle the assertions check three things. The BAR type bits never move. Every error pulse follows a strobe, and bad sizes and read-only byte writes always produce one. Command-word writes leave status untouched, ROM probes read back all ones, and narrow reads carry zero upper bytes. Several behaviours show only in the bench's scenarios: the exact probe masks, the preserved low bits of a programmed BAR, the window edges at base and base + size, and the rule that a zero write or a second probe leaves a placed window alone. The same goes for unimplemented BARs staying silent and windows vanishing after reset.

// File: rtl/pci_cfg_header.sv
module pci_cfg_header #(
  parameter logic [15:0] VENDOR_ID    = 16'hA5C3,
  parameter logic [15:0] DEVICE_ID    = 16'h0B17,
  parameter logic [15:0] CMD_INIT     = 16'h0000,
  parameter logic [15:0] STATUS_INIT  = 16'h0200,
  parameter logic [7:0]  REVISION     = 8'h03,
  parameter logic [7:0]  PROG_IF      = 8'h00,
  parameter logic [7:0]  SUB_CLASS    = 8'h80,
  parameter logic [7:0]  BASE_CLASS   = 8'h02,
  parameter logic [7:0]  CLS_INIT     = 8'h00,
  parameter logic [7:0]  LAT_INIT     = 8'h00,
  parameter logic [7:0]  HDR_TYPE     = 8'h00,
  parameter logic [7:0]  SELF_TEST    = 8'h00,
  parameter logic [31:0] CIS_PTR      = 32'h0,
  parameter logic [15:0] SUBSYS_VID   = 16'h1111,
  parameter logic [15:0] SUBSYS_ID    = 16'h2222,
  parameter logic [31:0] ROM_INIT     = 32'h0,
  parameter logic [7:0]  IRQ_LINE     = 8'h0A,
  parameter logic [7:0]  IRQ_PIN      = 8'h01,
  parameter logic [7:0]  MIN_GRANT    = 8'h04,
  parameter logic [7:0]  MAX_LATENCY  = 8'h10,
  parameter int          NUM_BARS     = 6,
  parameter logic [NUM_BARS-1:0][31:0] BAR_SIZE =
    {32'h0000_0020, 32'h0, 32'h0001_0000, 32'h0, 32'h0000_1000, 32'h0000_0100},
  parameter logic [NUM_BARS-1:0][3:0] BAR_TYPE =
    {4'h1, 4'h0, 4'h4, 4'h0, 4'h8, 4'h1},
  parameter logic [31:0] IO_WIN_OFS   = 32'h4000_0000,
  parameter logic [31:0] MEM_WIN_OFS  = 32'h8000_0000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_rd,
  input  logic                cfg_wr,
  input  logic [5:0]          cfg_off,
  input  logic [2:0]          cfg_size,
  input  logic [31:0]         cfg_wdata,
  output logic [31:0]         cfg_rdata,
  output logic                cfg_err,
  input  logic [31:0]         bus_addr,
  output logic [NUM_BARS-1:0] bar_hit
);

  localparam logic [5:0] OFF_CMD  = 6'h04;
  localparam logic [5:0] OFF_STS  = 6'h06;
  localparam logic [5:0] OFF_CLS  = 6'h0C;
  localparam logic [5:0] OFF_LAT  = 6'h0D;
  localparam logic [5:0] OFF_BAR0 = 6'h10;
  localparam logic [5:0] OFF_ROM  = 6'h30;
  localparam logic [5:0] OFF_ILN  = 6'h3C;
  localparam logic [6:0] BAR_END  = 7'(OFF_BAR0) + 7'(4 * NUM_BARS);

  logic [15:0] cmd_q, sts_q;
  logic [7:0]  cls_q, lat_q, iln_q;
  logic [31:0] rom_q;
  logic [NUM_BARS-1:0][31:0] bar_q, win_base;
  logic [NUM_BARS-1:0]       win_vld;

  logic [7:0]  hdr [64];
  logic [31:0] rd_word;
  logic [6:0]  idx;

  function automatic logic [31:0] type_mask(input int i);
    return BAR_TYPE[i][0] ? 32'h3 : 32'hF;
  endfunction

  function automatic logic [31:0] base_mask(input int i);
    return BAR_TYPE[i][0] ? ~32'h1 : ~32'h3;
  endfunction

  // ---- access decode ----
  wire sz_ok  = cfg_size == 3'd1 || cfg_size == 3'd2 || cfg_size == 3'd4;
  wire w1_ok  = cfg_off == OFF_CLS || cfg_off == OFF_LAT || cfg_off == OFF_ILN;
  wire w2_ok  = cfg_off == OFF_CMD || cfg_off == OFF_STS || cfg_off == OFF_CLS;
  wire wr_err = cfg_wr && (!sz_ok || (cfg_size == 3'd1 && !w1_ok) ||
                           (cfg_size == 3'd2 && !w2_ok));
  wire rd_err = cfg_rd && !sz_ok;
  wire bar_wr = cfg_wr && cfg_size == 3'd4 && cfg_off >= OFF_BAR0 &&
                7'(cfg_off) < BAR_END && cfg_off[1:0] == 2'b00;
  wire [5:0] bar_idx = (cfg_off - OFF_BAR0) >> 2;

  // ---- byte view of the header ----
  always_comb begin
    foreach (hdr[i]) hdr[i] = 8'h00;
    {hdr[1], hdr[0]}   = VENDOR_ID;
    {hdr[3], hdr[2]}   = DEVICE_ID;
    {hdr[5], hdr[4]}   = cmd_q;
    {hdr[7], hdr[6]}   = sts_q;
    hdr[8]  = REVISION;
    hdr[9]  = PROG_IF;
    hdr[10] = SUB_CLASS;
    hdr[11] = BASE_CLASS;
    hdr[12] = cls_q;
    hdr[13] = lat_q;
    hdr[14] = HDR_TYPE;
    hdr[15] = SELF_TEST;
    for (int b = 0; b < NUM_BARS; b++)
      for (int k = 0; k < 4; k++)
        hdr[16 + 4*b + k] = bar_q[b][8*k +: 8];
    {hdr[43], hdr[42], hdr[41], hdr[40]} = CIS_PTR;
    {hdr[45], hdr[44]} = SUBSYS_VID;
    {hdr[47], hdr[46]} = SUBSYS_ID;
    {hdr[51], hdr[50], hdr[49], hdr[48]} = rom_q;
    hdr[60] = iln_q;
    hdr[61] = IRQ_PIN;
    hdr[62] = MIN_GRANT;
    hdr[63] = MAX_LATENCY;
  end

  always_comb begin
    rd_word = '0;
    idx     = '0;
    for (int k = 0; k < 4; k++) begin
      idx = {1'b0, cfg_off} + 7'(k);
      if (3'(k) < cfg_size && !idx[6])
        rd_word[8*k +: 8] = hdr[idx[5:0]];
    end
  end

  // ---- state ----
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_rdata <= '0;
      cfg_err   <= 1'b0;
      cmd_q     <= CMD_INIT;
      sts_q     <= STATUS_INIT;
      cls_q     <= CLS_INIT;
      lat_q     <= LAT_INIT;
      iln_q     <= IRQ_LINE;
      rom_q     <= ROM_INIT;
      win_vld   <= '0;
      win_base  <= '0;
      for (int i = 0; i < NUM_BARS; i++)
        bar_q[i] <= (BAR_SIZE[i] != 0) ? (32'(BAR_TYPE[i]) & type_mask(i)) : '0;
    end else begin
      cfg_err <= rd_err | wr_err;
      if (cfg_rd)
        cfg_rdata <= sz_ok ? rd_word : '0;
      if (cfg_wr && !wr_err) begin
        if (cfg_size == 3'd1) begin
          case (cfg_off)
            OFF_CLS: cls_q <= cfg_wdata[7:0];
            OFF_LAT: lat_q <= cfg_wdata[7:0];
            OFF_ILN: iln_q <= cfg_wdata[7:0];
            default: ;
          endcase
        end else if (cfg_size == 3'd2) begin
          case (cfg_off)
            OFF_CMD: cmd_q <= cfg_wdata[15:0];
            OFF_STS: sts_q <= cfg_wdata[15:0];
            OFF_CLS: {lat_q, cls_q} <= cfg_wdata[15:0];
            default: ;
          endcase
        end else begin
          if (cfg_off == OFF_CMD) cmd_q <= cfg_wdata[15:0];
          if (cfg_off == OFF_ROM) rom_q <= (cfg_wdata == 32'hFFFF_FFFE) ? '1 : cfg_wdata;
        end
      end
      for (int i = 0; i < NUM_BARS; i++) begin
        if (bar_wr && bar_idx == 6'(i) && BAR_SIZE[i] != 0) begin
          if (cfg_wdata == '1) begin
            bar_q[i] <= ~(BAR_SIZE[i] - 32'd1) | (bar_q[i] & type_mask(i));
          end else begin
            bar_q[i] <= (cfg_wdata & ~type_mask(i)) | (bar_q[i] & type_mask(i));
            if ((cfg_wdata & base_mask(i)) != '0) begin
              win_base[i] <= (cfg_wdata & base_mask(i)) +
                             (BAR_TYPE[i][0] ? IO_WIN_OFS : MEM_WIN_OFS);
              win_vld[i]  <= 1'b1;
            end
          end
        end
      end
    end
  end

  // ---- window decode ----
  always_comb
    for (int i = 0; i < NUM_BARS; i++)
      bar_hit[i] = win_vld[i] && ((bus_addr - win_base[i]) < BAR_SIZE[i]);

  // ---- assertions ----
  // R2
  bad_size_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd || cfg_wr) && cfg_size == 3'd3 |=> cfg_err);

  // R2
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_err) |-> $past(cfg_rd || cfg_wr));

  // R3
  ro_byte_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr && cfg_size == 3'd1 && cfg_off != OFF_CLS && cfg_off != OFF_LAT &&
    cfg_off != OFF_ILN |=> cfg_err);

  // R5
  cmd_word_sts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr && cfg_size == 3'd4 && cfg_off == OFF_CMD |=> $stable(sts_q));

  // R8
  rom_probe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr && cfg_size == 3'd4 && cfg_off == OFF_ROM && cfg_wdata == 32'hFFFF_FFFE
    |=> rom_q == 32'hFFFF_FFFF);

  // R1
  narrow_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rd && cfg_size == 3'd1 |=> cfg_rdata[31:8] == 24'h0);

  for (genvar g = 0; g < NUM_BARS; g++) begin : g_bar_chk
    localparam logic [31:0] TM = BAR_TYPE[g][0] ? 32'h3 : 32'hF;
    // R7
    type_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(bar_q[g] & TM));
  end

endmodule

// File: tb/tb_pci_cfg_header.sv
module tb_pci_cfg_header;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_rd = 1'b0, cfg_wr = 1'b0;
  logic [5:0]  cfg_off = '0;
  logic [2:0]  cfg_size = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        cfg_err;
  logic [31:0] bus_addr = '0;
  logic [5:0]  bar_hit;

  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  pci_cfg_header dut (
    .clk(clk), .rst_n(rst_n), .cfg_rd(cfg_rd), .cfg_wr(cfg_wr),
    .cfg_off(cfg_off), .cfg_size(cfg_size), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .cfg_err(cfg_err), .bus_addr(bus_addr),
    .bar_hit(bar_hit)
  );

  // {wr, size, off, wdata, expected rdata, expected err, requirement}
  localparam int NV = 46;
  localparam logic [78:0] VEC [NV] = '{
    {1'b0, 3'd4, 6'h00, 32'h0, 32'h0B17A5C3, 1'b0, 4'd1},  // R1 ids
    {1'b0, 3'd2, 6'h02, 32'h0, 32'h00000B17, 1'b0, 4'd1},  // R1
    {1'b0, 3'd1, 6'h0B, 32'h0, 32'h00000002, 1'b0, 4'd1},  // R1
    {1'b0, 3'd4, 6'h08, 32'h0, 32'h02800003, 1'b0, 4'd1},  // R1
    {1'b0, 3'd4, 6'h3E, 32'h0, 32'h00001004, 1'b0, 4'd1},  // R1 past end
    {1'b0, 3'd3, 6'h00, 32'h0, 32'h00000000, 1'b1, 4'd2},  // R2
    {1'b1, 3'd3, 6'h0C, 32'h55, 32'h0, 1'b1, 4'd2},        // R2
    {1'b0, 3'd1, 6'h0C, 32'h0, 32'h00000000, 1'b0, 4'd2},  // R2 unchanged
    {1'b1, 3'd1, 6'h0C, 32'h40, 32'h0, 1'b0, 4'd3},        // R3
    {1'b1, 3'd1, 6'h0D, 32'h20, 32'h0, 1'b0, 4'd3},        // R3
    {1'b1, 3'd1, 6'h3C, 32'h07, 32'h0, 1'b0, 4'd3},        // R3
    {1'b0, 3'd4, 6'h3C, 32'h0, 32'h10040107, 1'b0, 4'd3},  // R3
    {1'b1, 3'd1, 6'h00, 32'hFF, 32'h0, 1'b1, 4'd3},        // R3 rejected
    {1'b0, 3'd2, 6'h00, 32'h0, 32'h0000A5C3, 1'b0, 4'd3},  // R3
    {1'b0, 3'd2, 6'h0C, 32'h0, 32'h00002040, 1'b0, 4'd3},  // R3
    {1'b1, 3'd2, 6'h0C, 32'h1234, 32'h0, 1'b0, 4'd4},      // R4
    {1'b1, 3'd2, 6'h04, 32'h0007, 32'h0, 1'b0, 4'd4},      // R4
    {1'b1, 3'd2, 6'h06, 32'hBEEF, 32'h0, 1'b0, 4'd4},      // R4
    {1'b1, 3'd2, 6'h08, 32'hFFFF, 32'h0, 1'b1, 4'd4},      // R4 rejected
    {1'b0, 3'd4, 6'h04, 32'h0, 32'hBEEF0007, 1'b0, 4'd4},  // R4
    {1'b0, 3'd4, 6'h08, 32'h0, 32'h02800003, 1'b0, 4'd4},  // R4
    {1'b0, 3'd4, 6'h0C, 32'h0, 32'h00001234, 1'b0, 4'd4},  // R4
    {1'b1, 3'd4, 6'h04, 32'hFFFF0106, 32'h0, 1'b0, 4'd5},  // R5
    {1'b0, 3'd4, 6'h04, 32'h0, 32'hBEEF0106, 1'b0, 4'd5},  // R5
    {1'b1, 3'd4, 6'h00, 32'hDEADBEEF, 32'h0, 1'b0, 4'd5},  // R5 ignored
    {1'b0, 3'd4, 6'h00, 32'h0, 32'h0B17A5C3, 1'b0, 4'd5},  // R5
    {1'b0, 3'd4, 6'h10, 32'h0, 32'h00000001, 1'b0, 4'd6},  // R6
    {1'b1, 3'd4, 6'h10, 32'hFFFFFFFF, 32'h0, 1'b0, 4'd6},  // R6
    {1'b0, 3'd4, 6'h10, 32'h0, 32'hFFFFFF01, 1'b0, 4'd6},  // R6 io probe
    {1'b1, 3'd4, 6'h14, 32'hFFFFFFFF, 32'h0, 1'b0, 4'd6},  // R6
    {1'b0, 3'd4, 6'h14, 32'h0, 32'hFFFFF008, 1'b0, 4'd6},  // R6 mem probe
    {1'b1, 3'd4, 6'h1C, 32'hFFFFFFFF, 32'h0, 1'b0, 4'd6},  // R6
    {1'b0, 3'd4, 6'h1C, 32'h0, 32'hFFFF0004, 1'b0, 4'd6},  // R6
    {1'b1, 3'd4, 6'h10, 32'h0000A000, 32'h0, 1'b0, 4'd7},  // R7
    {1'b0, 3'd4, 6'h10, 32'h0, 32'h0000A001, 1'b0, 4'd7},  // R7
    {1'b1, 3'd4, 6'h14, 32'h12340003, 32'h0, 1'b0, 4'd7},  // R7
    {1'b0, 3'd4, 6'h14, 32'h0, 32'h12340008, 1'b0, 4'd7},  // R7
    {1'b1, 3'd4, 6'h18, 32'hFFFFFFFF, 32'h0, 1'b0, 4'd11}, // R11
    {1'b0, 3'd4, 6'h18, 32'h0, 32'h00000000, 1'b0, 4'd11}, // R11
    {1'b1, 3'd4, 6'h30, 32'hFFFFFFFE, 32'h0, 1'b0, 4'd8},  // R8
    {1'b0, 3'd4, 6'h30, 32'h0, 32'hFFFFFFFF, 1'b0, 4'd8},  // R8
    {1'b1, 3'd4, 6'h30, 32'h000C0001, 32'h0, 1'b0, 4'd8},  // R8
    {1'b0, 3'd4, 6'h30, 32'h0, 32'h000C0001, 1'b0, 4'd8},  // R8
    {1'b1, 3'd4, 6'h24, 32'h00000000, 32'h0, 1'b0, 4'd10}, // R10
    {1'b0, 3'd4, 6'h24, 32'h0, 32'h00000001, 1'b0, 4'd10}, // R10
    {1'b0, 3'd5, 6'h00, 32'h0, 32'h00000000, 1'b1, 4'd2}   // R2 size 5
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [2:0] sz, input logic [5:0] off,
                        input logic [31:0] wd);
    @(negedge clk);
    cfg_rd = !wr; cfg_wr = wr; cfg_size = sz; cfg_off = off; cfg_wdata = wd;
    @(negedge clk);
    cfg_rd = 1'b0; cfg_wr = 1'b0;
  endtask

  task automatic hit_at(input string req, input logic [31:0] a, input logic [5:0] exp);
    @(negedge clk);
    bus_addr = a;
    #1 chk(req, 32'(bar_hit), 32'(exp));
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    chk("R1 rdata after reset", cfg_rdata, 32'h0);
    chk("R1 err after reset", 32'(cfg_err), 32'h0);
    chk("R1 hit after reset", 32'(bar_hit), 32'h0);

    for (int i = 0; i < NV; i++) begin
      access(VEC[i][78], VEC[i][77:75], VEC[i][74:69], VEC[i][68:37]);
      if (!VEC[i][78])
        chk($sformatf("R%0d data vec %0d", VEC[i][3:0], i), cfg_rdata, VEC[i][36:5]);
      chk($sformatf("R%0d err vec %0d", VEC[i][3:0], i), 32'(cfg_err), 32'(VEC[i][4]));
    end

    // R2 error is a single-cycle pulse
    access(1'b1, 3'd3, 6'h04, 32'h0);
    @(negedge clk);
    chk("R2 err drops", 32'(cfg_err), 32'h0);

    // R9 window edges: BAR0 io 0x4000A000 size 0x100, BAR1 mem 0x92340000 size 0x1000
    hit_at("R9 bar0 low edge", 32'h4000A000, 6'b000001);
    hit_at("R9 bar0 high edge", 32'h4000A0FF, 6'b000001);
    hit_at("R9 bar0 above", 32'h4000A100, 6'b000000);
    hit_at("R9 bar0 below", 32'h40009FFF, 6'b000000);
    hit_at("R9 bar1 high edge", 32'h92340FFF, 6'b000010);
    hit_at("R9 bar1 above", 32'h92341000, 6'b000000);

    // R10 probed-only and zero-written BARs never hit
    hit_at("R10 bar3 unplaced", 32'h80000000, 6'b000000);
    hit_at("R10 bar5 unplaced", 32'h40000000, 6'b000000);
    access(1'b1, 3'd4, 6'h14, 32'h00000000);
    hit_at("R10 zero write keeps window", 32'h92340010, 6'b000010);
    access(1'b1, 3'd4, 6'h10, 32'hFFFFFFFF);
    hit_at("R10 probe keeps window", 32'h4000A010, 6'b000001);

    // R11 unimplemented BAR
    access(1'b1, 3'd4, 6'h18, 32'h00100000);
    hit_at("R11 no hit", 32'h80100000, 6'b000000);
    access(1'b0, 3'd4, 6'h18, 32'h0);
    chk("R11 reads zero", cfg_rdata, 32'h0);

    // reset again
    do_reset();
    access(1'b0, 3'd4, 6'h04, 32'h0);
    chk("R1 command/status reset", cfg_rdata, 32'h02000000);
    access(1'b0, 3'd4, 6'h10, 32'h0);
    chk("R1 bar0 reset", cfg_rdata, 32'h00000001);
    hit_at("R10 reset clears window", 32'h4000A010, 6'b000000);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule